// File: doc/BRIEF.md
# Multi-Channel DMA Engine with Pre-emption Context Save

The block moves data for several DMA channels, one element per beat, over an abstract beat interface. Each beat carries a source address, a destination address and the number of the channel it belongs to. Software first writes a per-channel setup entry through a configuration port: a frame count, an element count per frame, a source start address and a destination start address. It then raises that channel's bit on `en_set`. A block consists of the given number of frames, and each frame holds the given number of elements. Both addresses step up by one after every accepted beat.

Channels compete under fixed priority, and the lowest index wins. The choice is made only when a frame ends, so a frame that has started always finishes. A channel is pre-empted when a lower-indexed channel is enabled at the end of one of its frames and it still has frames to send. In that case its working state is written to a shared context store: the frames remaining, the element count of the next frame, and the next source and destination addresses. When the channel is granted again, it reloads that state. The engine writes nothing to the store in any other situation: not at the end of a block, not at a frame end with no higher request pending, and not when only one channel is enabled. The stored fields therefore serve as engine scratch, and they can be read through a read-only port. Progress is reported through per-channel one-cycle status pulses: frame done, half block, block done and last frame.

Top module: `dma_ctx_sched`

## Requirements
- R1: A `cfg_we` pulse stores frame count, element count, source and destination start values for channel `cfg_ch`. Counts must be nonzero. An `en_set` bit sets the channel's enable if it is clear. On the channel's first grant, its beats start at the stored start addresses, and both addresses rise by one per accepted beat. It issues frames × elements beats in total.
- R2: While `beat_valid` is high and `beat_ready` is low, the beat's channel and addresses hold steady and `beat_valid` stays high.
- R3: Among enabled channels, the lowest index is granted. Arbitration happens only at a frame end or while idle, so consecutive beats within a frame always belong to the same channel.
- R4: A frame end that leaves frames outstanding, with a lower-indexed channel enabled at that moment, writes the context entry of the running channel. The entry holds the remaining frames, the configured element count, and the next source and destination addresses. The engine then switches to the lower-indexed channel.
- R5: A pre-empted channel resumes, when granted again, at the saved addresses and finishes its remaining frames.
- R6: A frame end with frames outstanding and no lower-indexed channel enabled continues the same channel and leaves its context entry unchanged.
- R7: The frame end that completes a block never writes the context entry, whether or not a higher-priority channel is enabled.
- R8: A channel that runs alone from enable to block completion leaves its context entry unchanged. The context store reads zero after reset until the first save.
- R9: `st_frame[c]` pulses for one cycle after each frame of channel c ends. `st_block[c]` pulses once, in the cycle in which the final frame's pulse appears.
- R10: `st_half[c]` pulses once, at the frame end where the completed frame count equals floor(frames/2). It does not pulse when that value is 0.
- R11: `st_last[c]` pulses once, when the channel's final frame begins. That is at the grant when one frame remains, or alongside the frame-done pulse that leaves one frame.
- R12: The channel's enable (`ch_active`) clears on block completion. A later `en_set` restarts the channel from its configured start values.
- R13: After reset, `beat_valid` is low, `ch_active` is zero and all status pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setup entry write strobe |
| cfg_ch | input | CHW | Channel selected for the setup write |
| cfg_frames | input | FCW | Frames per block |
| cfg_elems | input | ECW | Elements per frame |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| en_set | input | NCH | Per-channel enable request pulses |
| ch_active | output | NCH | Per-channel enable state |
| beat_valid | output | 1 | A beat is offered |
| beat_ready | input | 1 | The beat is accepted on this clock edge |
| beat_ch | output | CHW | Channel of the offered beat |
| beat_src | output | AW | Source address of the beat |
| beat_dst | output | AW | Destination address of the beat |
| st_frame | output | NCH | Frame-done pulses |
| st_half | output | NCH | Half-block pulses |
| st_block | output | NCH | Block-done pulses |
| st_last | output | NCH | Last-frame-begins pulses |
| ctx_rd_ch | input | CHW | Channel whose context entry is read |
| ctx_rd_frames | output | FCW | Stored remaining frames |
| ctx_rd_elems | output | ECW | Stored element count |
| ctx_rd_src | output | AW | Stored next source address |
| ctx_rd_dst | output | AW | Stored next destination address |

## Verification
The first beat of a channel appears two clock edges after its `en_set` pulse: one edge registers the enable and the next edge loads the working registers. A context save becomes visible on the read port in the cycle after the frame-ending beat is accepted, and so do the status pulses. The bench samples every output at the falling edge. Beats are compared against a queue of expected items at the falling edge before the accepting rising edge. Pre-emption requests are issued after a beat count that leaves at least one full frame-ending edge of margin, and the context store is read only once the next channel's beats have been observed.

// File: rtl/dma_ctx_pkg.sv
package dma_ctx_pkg;
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;
endpackage

// File: rtl/dma_ctx_ram.sv
module dma_ctx_ram #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    parameter int NRD   = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [$clog2(DEPTH)-1:0]         waddr,
    input  logic [DW-1:0]                    wdata,
    input  logic [NRD*$clog2(DEPTH)-1:0]     raddr,
    output logic [NRD*DW-1:0]                rdata
);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rdata[r*DW +: DW] = mem_q[raddr[r*IW +: IW]];
    end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int N = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          req,
    input  logic [$clog2(N)-1:0]  cur_idx,
    output logic [N-1:0]          grant,
    output logic [$clog2(N)-1:0]  grant_idx,
    output logic                  any,
    output logic                  higher
);
    localparam int IW = $clog2(N);

    for (genvar i = 0; i < N; i++) begin : g_gnt
        if (i == 0) begin : g_first
            assign grant[i] = req[i];
        end else begin : g_rest
            assign grant[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    assign any = |req;

    always_comb begin
        grant_idx = '0;
        higher    = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) grant_idx = IW'(i);
            if (req[i] && (i < int'(cur_idx))) higher = 1'b1;
        end
    end

    // R3: only one grant, only to a requester
    p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
endmodule

// File: rtl/dma_ctx_sched.sv
module dma_ctx_sched #(
    parameter int NCH = 4,
    parameter int FCW = 8,
    parameter int ECW = 8,
    parameter int AW  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(NCH)-1:0]   cfg_ch,
    input  logic [FCW-1:0]           cfg_frames,
    input  logic [ECW-1:0]           cfg_elems,
    input  logic [AW-1:0]            cfg_src,
    input  logic [AW-1:0]            cfg_dst,
    input  logic [NCH-1:0]           en_set,
    output logic [NCH-1:0]           ch_active,
    output logic                     beat_valid,
    input  logic                     beat_ready,
    output logic [$clog2(NCH)-1:0]   beat_ch,
    output logic [AW-1:0]            beat_src,
    output logic [AW-1:0]            beat_dst,
    output logic [NCH-1:0]           st_frame,
    output logic [NCH-1:0]           st_half,
    output logic [NCH-1:0]           st_block,
    output logic [NCH-1:0]           st_last,
    input  logic [$clog2(NCH)-1:0]   ctx_rd_ch,
    output logic [FCW-1:0]           ctx_rd_frames,
    output logic [ECW-1:0]           ctx_rd_elems,
    output logic [AW-1:0]            ctx_rd_src,
    output logic [AW-1:0]            ctx_rd_dst
);
    import dma_ctx_pkg::*;

    localparam int CHW = $clog2(NCH);
    localparam int EW  = FCW + ECW + 2 * AW;

    typedef struct packed {
        logic [FCW-1:0] frames;
        logic [ECW-1:0] elems;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
    } entry_t;

    typedef struct packed {
        eng_state_e     st;
        logic [CHW-1:0] ch;
        logic [FCW-1:0] frames;
        logic [ECW-1:0] elems;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic [NCH-1:0] en;
        logic [NCH-1:0] started;
        logic [NCH-1:0] fdone;
        logic [NCH-1:0] hdone;
        logic [NCH-1:0] bdone;
        logic [NCH-1:0] lastf;
    } eng_t;

    eng_t q, d;

    // setup store and context store
    entry_t         init_wr, init_cur;
    logic [CHW-1:0] init_raddr;
    entry_t         ctx_wdata, ctx_ld, ctx_dbg;
    logic           ctx_we;
    logic [2*EW-1:0] ctx_rdata;

    assign init_wr = '{frames: cfg_frames, elems: cfg_elems, src: cfg_src, dst: cfg_dst};

    // arbitration
    logic [NCH-1:0] grant;
    logic [CHW-1:0] gidx;
    logic           g_any, g_higher;

    assign init_raddr = (q.st == ENG_RUN) ? q.ch : gidx;

    dma_ctx_ram #(.DEPTH(NCH), .DW(EW), .NRD(1)) i_init_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_ch),
        .wdata (init_wr),
        .raddr (init_raddr),
        .rdata (init_cur)
    );

    dma_ctx_ram #(.DEPTH(NCH), .DW(EW), .NRD(2)) i_ctx_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctx_we),
        .waddr (q.ch),
        .wdata (ctx_wdata),
        .raddr ({ctx_rd_ch, gidx}),
        .rdata (ctx_rdata)
    );

    assign ctx_ld  = ctx_rdata[EW-1:0];
    assign ctx_dbg = ctx_rdata[2*EW-1:EW];

    dma_prio_arb #(.N(NCH)) i_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (q.en),
        .cur_idx   (q.ch),
        .grant     (grant),
        .grant_idx (gidx),
        .any       (g_any),
        .higher    (g_higher)
    );

    // next-state logic
    logic [FCW-1:0] nf;
    logic [FCW-1:0] half_pt;
    entry_t         ld;

    always_comb begin
        d         = q;
        d.fdone   = '0;
        d.hdone   = '0;
        d.bdone   = '0;
        d.lastf   = '0;
        ctx_we    = 1'b0;
        ctx_wdata = '0;
        nf        = q.frames - FCW'(1);
        half_pt   = init_cur.frames >> 1;
        ld        = q.started[gidx] ? ctx_ld : init_cur;

        for (int i = 0; i < NCH; i++) begin
            if (en_set[i] && !q.en[i]) begin
                d.en[i]      = 1'b1;
                d.started[i] = 1'b0;
            end
        end

        if (q.st == ENG_IDLE) begin
            if (g_any) begin
                d.st            = ENG_RUN;
                d.ch            = gidx;
                d.frames        = ld.frames;
                d.elems         = ld.elems;
                d.src           = ld.src;
                d.dst           = ld.dst;
                d.started[gidx] = 1'b1;
                if (ld.frames == FCW'(1)) d.lastf[gidx] = 1'b1;
            end
        end else if (beat_ready) begin
            d.src   = q.src + AW'(1);
            d.dst   = q.dst + AW'(1);
            d.elems = q.elems - ECW'(1);
            if (q.elems == ECW'(1)) begin
                d.fdone[q.ch] = 1'b1;
                d.frames      = nf;
                d.elems       = init_cur.elems;
                if ((half_pt != '0) && ((init_cur.frames - nf) == half_pt))
                    d.hdone[q.ch] = 1'b1;
                if (nf == '0) begin
                    d.bdone[q.ch]   = 1'b1;
                    d.en[q.ch]      = 1'b0;
                    d.started[q.ch] = 1'b0;
                    d.st            = ENG_IDLE;
                end else if (g_higher) begin
                    ctx_we    = 1'b1;
                    ctx_wdata = '{frames: nf, elems: init_cur.elems,
                                  src: q.src + AW'(1), dst: q.dst + AW'(1)};
                    d.st      = ENG_IDLE;
                end else if (nf == FCW'(1)) begin
                    d.lastf[q.ch] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ENG_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ch_active     = q.en;
    assign beat_valid    = (q.st == ENG_RUN);
    assign beat_ch       = q.ch;
    assign beat_src      = q.src;
    assign beat_dst      = q.dst;
    assign st_frame      = q.fdone;
    assign st_half       = q.hdone;
    assign st_block      = q.bdone;
    assign st_last       = q.lastf;
    assign ctx_rd_frames = ctx_dbg.frames;
    assign ctx_rd_elems  = ctx_dbg.elems;
    assign ctx_rd_src    = ctx_dbg.src;
    assign ctx_rd_dst    = ctx_dbg.dst;

    // R2: an offered beat holds until taken
    p_hold_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_ch)
                                         && $stable(beat_src) && $stable(beat_dst)));
    // R3: no switch inside a frame
    p_no_mid_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && q.elems != ECW'(1)) |=> (beat_valid && beat_ch == $past(beat_ch)));
    // R4: a save always hands the engine over
    p_save_yields_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_we |=> !beat_valid);
    // R7: block completion never coincides with a save
    p_no_save_at_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_block) |-> !$past(ctx_we));
    // R12: enable drops with block completion
    p_block_clears_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_block & ch_active) == '0);
    // R12: beats only for enabled channels
    p_beat_enabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> ch_active[beat_ch]);
endmodule

// File: tb/test_dma_ctx_sched.sv
module test_dma_ctx_sched;
    localparam int NCH = 4, FCW = 8, ECW = 8, AW = 16, CHW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [CHW-1:0] cfg_ch = '0;
    logic [FCW-1:0] cfg_frames = '0;
    logic [ECW-1:0] cfg_elems = '0;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [NCH-1:0] en_set = '0;
    logic [NCH-1:0] ch_active;
    logic beat_valid, beat_ready = 1'b1;
    logic [CHW-1:0] beat_ch;
    logic [AW-1:0] beat_src, beat_dst;
    logic [NCH-1:0] st_frame, st_half, st_block, st_last;
    logic [CHW-1:0] ctx_rd_ch = '0;
    logic [FCW-1:0] ctx_rd_frames;
    logic [ECW-1:0] ctx_rd_elems;
    logic [AW-1:0] ctx_rd_src, ctx_rd_dst;

    always #2.5 clk = ~clk;

    dma_ctx_sched #(.NCH(NCH), .FCW(FCW), .ECW(ECW), .AW(AW)) i_dma_ctx_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_frames(cfg_frames), .cfg_elems(cfg_elems), .cfg_src(cfg_src),
        .cfg_dst(cfg_dst), .en_set(en_set), .ch_active(ch_active),
        .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_ch(beat_ch),
        .beat_src(beat_src), .beat_dst(beat_dst), .st_frame(st_frame),
        .st_half(st_half), .st_block(st_block), .st_last(st_last),
        .ctx_rd_ch(ctx_rd_ch), .ctx_rd_frames(ctx_rd_frames),
        .ctx_rd_elems(ctx_rd_elems), .ctx_rd_src(ctx_rd_src), .ctx_rd_dst(ctx_rd_dst));

    typedef struct {
        int    ch;
        int    src;
        int    dst;
        string tag;
    } beat_t;

    beat_t exp_q[$];
    int n_checks = 0, n_fail = 0, nbeats = 0;
    int fcnt[NCH], hcnt[NCH], bcnt[NCH], lcnt[NCH], nfr[NCH];
    logic hold_pend = 1'b0;
    logic [AW-1:0] hold_src;
    logic [CHW-1:0] hold_ch;
    bit rand_ready = 1'b0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // monitor: scoreboard and status pulse accounting
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend)
                check(beat_valid && beat_src == hold_src && beat_ch == hold_ch,
                      "R2 held beat", int'(beat_src), int'(hold_src));
            hold_pend = beat_valid && !beat_ready;
            hold_src  = beat_src;
            hold_ch   = beat_ch;
            if (beat_valid && beat_ready) begin
                nbeats++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected beat", int'(beat_src), -1);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    check(int'(beat_ch) == e.ch, {e.tag, " beat channel"}, int'(beat_ch), e.ch);
                    check(int'(beat_src) == e.src && int'(beat_dst) == e.dst,
                          {e.tag, " beat address"}, int'(beat_src), e.src);
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (st_frame[c]) fcnt[c]++;
                if (st_half[c]) begin
                    hcnt[c]++;
                    check(fcnt[c] == nfr[c] / 2, "R10 half timing", fcnt[c], nfr[c] / 2);
                end
                if (st_last[c]) begin
                    lcnt[c]++;
                    check(fcnt[c] == nfr[c] - 1, "R11 last timing", fcnt[c], nfr[c] - 1);
                end
                if (st_block[c]) begin
                    bcnt[c]++;
                    check(fcnt[c] == nfr[c], "R9 block timing", fcnt[c], nfr[c]);
                end
            end
        end
    end

    // ready pattern
    always @(posedge clk) begin
        #1 beat_ready = rand_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    task automatic cfg(input int ch, input int f, input int e, input int s, input int dd);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_frames = FCW'(f); cfg_elems = ECW'(e);
        cfg_src = AW'(s); cfg_dst = AW'(dd);
        nfr[ch] = f;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic enable(input logic [NCH-1:0] m);
        @(posedge clk); #1;
        en_set = m;
        @(posedge clk); #1;
        en_set = '0;
    endtask

    task automatic push_run(input int ch, input int s, input int dd, input int n, input string tag);
        for (int i = 0; i < n; i++) exp_q.push_back('{ch, s + i, dd + i, tag});
    endtask

    task automatic clear_counts();
        for (int c = 0; c < NCH; c++) begin
            fcnt[c] = 0; hcnt[c] = 0; bcnt[c] = 0; lcnt[c] = 0;
        end
    endtask

    task automatic wait_beats(input int target);
        for (int i = 0; i < 5000 && nbeats < target; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && (exp_q.size() != 0 || ch_active != '0); i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1 all beats seen", exp_q.size(), 0);
    endtask

    task automatic read_ctx(input int ch, input int f, input int e, input int s, input int dd,
                            input string tag);
        @(posedge clk); #1;
        ctx_rd_ch = CHW'(ch);
        @(negedge clk);
        check(int'(ctx_rd_frames) == f && int'(ctx_rd_elems) == e,
              {tag, " context counts"}, int'(ctx_rd_frames), f);
        check(int'(ctx_rd_src) == s && int'(ctx_rd_dst) == dd,
              {tag, " context addresses"}, int'(ctx_rd_src), s);
    endtask

    task automatic check_status(input int ch, input string tag);
        check(fcnt[ch] == nfr[ch], {tag, " R9 frame pulses"}, fcnt[ch], nfr[ch]);
        check(bcnt[ch] == 1, {tag, " R9 block pulses"}, bcnt[ch], 1);
        check(hcnt[ch] == ((nfr[ch] >= 2) ? 1 : 0), {tag, " R10 half pulses"}, hcnt[ch],
              (nfr[ch] >= 2) ? 1 : 0);
        check(lcnt[ch] == 1, {tag, " R11 last pulses"}, lcnt[ch], 1);
        check(ch_active[ch] == 1'b0, {tag, " R12 enable cleared"}, int'(ch_active[ch]), 0);
    endtask

    initial begin
        int base;
        clear_counts();
        repeat (3) @(negedge clk);
        // R13 reset state
        check(beat_valid == 1'b0, "R13 no beat in reset", int'(beat_valid), 0);
        check(ch_active == '0, "R13 enables clear", int'(ch_active), 0);
        check((st_frame | st_half | st_block | st_last) == '0, "R13 status low", 0, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(beat_valid == 1'b0 && ch_active == '0, "R13 idle after reset", int'(beat_valid), 0);
        read_ctx(3, 0, 0, 0, 0, "R8 reset");

        cfg(0, 3, 2, 'h100, 'h800);
        cfg(1, 2, 2, 'h200, 'h900);
        cfg(2, 3, 2, 'h300, 'hA00);
        cfg(3, 4, 3, 'h400, 'hB00);

        // lone channel with stalls (R1, R2, R8)
        clear_counts();
        rand_ready = 1'b1;
        push_run(2, 'h300, 'hA00, 6, "R1");
        enable(4'b0100);
        wait_idle();
        rand_ready = 1'b0;
        check_status(2, "lone");
        read_ctx(2, 0, 0, 0, 0, "R8 lone channel");

        // pre-emption and resume (R3, R4, R5, R7)
        clear_counts();
        base = nbeats;
        push_run(3, 'h400, 'hB00, 6, "R3");
        push_run(1, 'h200, 'h900, 4, "R3");
        push_run(3, 'h406, 'hB06, 6, "R5");
        enable(4'b1000);
        wait_beats(base + 3);
        enable(4'b0010);
        wait_beats(base + 7);
        read_ctx(3, 2, 3, 'h406, 'hB06, "R4 saved");
        wait_idle();
        check_status(3, "preempted");
        check_status(1, "preemptor");
        read_ctx(3, 2, 3, 'h406, 'hB06, "R7 untouched after block");

        // block ends while higher pending (R7)
        cfg(2, 1, 3, 'h310, 'hA10);
        clear_counts();
        base = nbeats;
        push_run(2, 'h310, 'hA10, 3, "R7");
        push_run(0, 'h100, 'h800, 6, "R3");
        enable(4'b0100);
        wait_beats(base + 1);
        enable(4'b0001);
        wait_idle();
        check_status(2, "final with pending");
        read_ctx(2, 0, 0, 0, 0, "R7 no save at block end");

        // frame ends with only lower priority pending (R6, R3)
        cfg(2, 2, 1, 'h320, 'hA20);
        clear_counts();
        push_run(0, 'h100, 'h800, 6, "R6");
        push_run(2, 'h320, 'hA20, 2, "R3");
        enable(4'b0101);
        wait_idle();
        check_status(0, "no higher");
        read_ctx(0, 0, 0, 0, 0, "R6 no save at frame end");

        // re-enable restarts from setup values (R12)
        clear_counts();
        rand_ready = 1'b1;
        push_run(3, 'h400, 'hB00, 12, "R12");
        enable(4'b1000);
        wait_idle();
        rand_ready = 1'b0;
        check_status(3, "restart");
        finish_run();
    end

    initial begin
        #200000;
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule